// File: doc/BRIEF.md
# Multi-mode Registered Bus Transceiver Core

This block is the logic core of an 18-bit bidirectional bus transceiver. It has two directions that run independently. The A-to-B direction takes data from the A side and drives the B side. The B-to-A direction takes data from the B side and drives the A side. Each direction has one storage stage with four controls: a sampled clock strobe, an active-low clock enable, an active-high latch enable and an active-low output enable. Depending on those controls, the stage passes data straight through, holds it, or captures it on a rising edge of its clock strobe.

The A side is modelled as a three-state driver: a value vector plus a per-bit drive enable. The B side is modelled as an open-drain, wired-OR driver. Its level is always 0, and its per-bit enable means "pull low". A stored 1 therefore releases the line, so that external termination can pull it high.

All state is clocked by one system clock with a synchronous active-high reset. The direction clocks are treated as strobes that the system clock samples. Integrating logic drives the controls synchronously to that system clock and never enables both directions at the same time.

Top module: `xcvr_core`

## Requirements
- R1: While reset is high, no bit of `a_out_en` or `b_out_en` is set. After reset, both stored values are 0.
- R2: When a direction's latch enable is 1, its output data equals its input data in the same cycle, whatever its clock enable and clock strobe are doing.
- R3: When latch enable is 0 and clock enable is 0 at a system clock edge where the clock strobe is seen rising, the input is stored and appears on the output after that edge.
- R4: With latch enable 0 and no rising strobe, the stored value is kept. This holds whether the strobe rests at 1 or at 0.
- R5: With clock enable 1 and latch enable 0, strobe rises are ignored and the stored value is kept.
- R6: When latch enable falls, the stage holds the input sampled at the last system clock edge at which latch enable was 1.
- R7: While a direction's output enable is 1, that direction drives nothing. For A-to-B, `b_out_en` is all 0. For B-to-A, `a_out_en` and `a_out` are all 0.
- R8: The B side is open drain. `b_out` is always 0. When A-to-B is enabled, `b_out_en[i]` is 1 exactly when data bit i is 0.
- R9: When B-to-A is enabled, `a_out_en` is all ones and `a_out` carries the stage's data.
- R10: The two directions are independent. Activity on one direction's controls or data never changes the other direction's stored value.
- R11: The clock enable is sampled only at the system clock edge where the strobe rise is seen. A low clock enable in a cycle without a rise causes no capture.
- R12: A rise is counted only when the strobe is 0 at one system clock edge and 1 at the next. The first edge after reset treats the strobe as previously 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 18 | A-side data into the A-to-B stage |
| b_in | input | 18 | B-side data into the B-to-A stage |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ab_le | input | 1 | A-to-B latch enable, transparent when 1 |
| ab_clk | input | 1 | A-to-B clock strobe |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| ba_le | input | 1 | B-to-A latch enable, transparent when 1 |
| ba_clk | input | 1 | B-to-A clock strobe |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| a_out | output | 18 | A-side drive value |
| a_out_en | output | 18 | A-side per-bit three-state enable |
| b_out | output | 18 | B-side drive level, always 0 |
| b_out_en | output | 18 | B-side per-bit pull-low enable |

## Verification
The assertions assume that every control and data input changes only between system clock edges. They also assume that integration logic never holds both output enables low at once, because that would put two drivers on one port. The stimulus changes all inputs on the falling edge of the system clock. It enables only one direction at a time, and a bench monitor reports any cycle in which both enables are low. Strobe rises are built from separate low and high cycles, so every capture point is unambiguous.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    parameter int unsigned XCVR_W = 18;

    typedef struct packed {
        logic ce_n;
        logic le;
        logic strobe;
        logic oe_n;
    } xcvr_ctl_t;

    // A rise is a strobe seen low at one edge and high at the next
    function automatic logic strobe_rose(input logic prev, input logic cur);
        return (!prev) && cur;
    endfunction

endpackage

// File: rtl/xcvr_stage.sv
module xcvr_stage
    import xcvr_pkg::*;
#(
    parameter int unsigned W = XCVR_W
) (
    input  logic            clk,
    input  logic            rst,
    input  xcvr_ctl_t       ctl,
    input  logic [W-1:0]    din,
    output logic [W-1:0]    dout,
    output logic            drive_en
);

    logic [W-1:0] held_q;
    logic         strobe_prev_q;
    logic         capture;

    assign capture = (!ctl.le) && (!ctl.ce_n) && strobe_rose(strobe_prev_q, ctl.strobe);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q        <= '0;
            strobe_prev_q <= 1'b1;
        end else begin
            strobe_prev_q <= ctl.strobe;
            if (ctl.le || capture) begin
                held_q <= din;
            end
        end
    end

    always_comb begin
        dout     = ctl.le ? din : held_q;
        drive_en = (!ctl.oe_n) && (!rst);
    end

endmodule

// File: rtl/xcvr_drv.sv
module xcvr_drv #(
    parameter int unsigned W          = 18,
    parameter bit          OPEN_DRAIN = 1'b0
) (
    input  logic [W-1:0] data,
    input  logic         en,
    output logic [W-1:0] pad_val,
    output logic [W-1:0] pad_en
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (OPEN_DRAIN) begin : g_od
            // only ever pulls low; a 1 releases the line
            assign pad_val[i] = 1'b0;
            assign pad_en[i]  = en & ~data[i];
        end else begin : g_pp
            assign pad_val[i] = en & data[i];
            assign pad_en[i]  = en;
        end
    end

endmodule

// File: rtl/xcvr_core.sv
module xcvr_core
    import xcvr_pkg::*;
#(
    parameter int unsigned W = XCVR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_ce_n,
    input  logic         ab_le,
    input  logic         ab_clk,
    input  logic         ab_oe_n,
    input  logic         ba_ce_n,
    input  logic         ba_le,
    input  logic         ba_clk,
    input  logic         ba_oe_n,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_out_en,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_out_en
);

    xcvr_ctl_t    ab_ctl, ba_ctl;
    logic [W-1:0] ab_data, ba_data;
    logic         ab_en, ba_en;

    assign ab_ctl = '{ce_n: ab_ce_n, le: ab_le, strobe: ab_clk, oe_n: ab_oe_n};
    assign ba_ctl = '{ce_n: ba_ce_n, le: ba_le, strobe: ba_clk, oe_n: ba_oe_n};

    xcvr_stage #(.W(W)) ab_stage_i (
        .clk(clk), .rst(rst), .ctl(ab_ctl), .din(a_in),
        .dout(ab_data), .drive_en(ab_en)
    );

    xcvr_stage #(.W(W)) ba_stage_i (
        .clk(clk), .rst(rst), .ctl(ba_ctl), .din(b_in),
        .dout(ba_data), .drive_en(ba_en)
    );

    xcvr_drv #(.W(W), .OPEN_DRAIN(1'b1)) b_drv_i (
        .data(ab_data), .en(ab_en), .pad_val(b_out), .pad_en(b_out_en)
    );

    xcvr_drv #(.W(W), .OPEN_DRAIN(1'b0)) a_drv_i (
        .data(ba_data), .en(ba_en), .pad_val(a_out), .pad_en(a_out_en)
    );

endmodule

// File: rtl/xcvr_core_chk.sv
module xcvr_core_chk #(
    parameter int unsigned W = 18
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         ab_ce_n,
    input logic         ab_le,
    input logic         ab_oe_n,
    input logic         ba_le,
    input logic         ba_oe_n,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_out_en,
    input logic [W-1:0] b_out_en
);

    always_comb begin
        if (rst) begin
            AST_RESET_QUIET: assert (a_out_en == '0 && b_out_en == '0); // R1
        end
    end

    AST_AB_OFF: assert property (@(posedge clk) disable iff (rst)
        ab_oe_n |-> (b_out_en == '0)); // R7

    AST_BA_OFF: assert property (@(posedge clk) disable iff (rst)
        ba_oe_n |-> (a_out_en == '0 && a_out == '0)); // R7

    AST_AB_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
        (ab_le && !ab_oe_n) |-> (b_out_en == ~a_in)); // R2

    AST_BA_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
        (ba_le && !ba_oe_n) |-> (a_out == b_in && a_out_en == '1)); // R9

    AST_AB_INHIBIT: assert property (@(posedge clk) disable iff (rst)
        (!ab_le && !ab_oe_n && $past(!rst && !ab_le && ab_ce_n && !ab_oe_n))
        |-> $stable(b_out_en)); // R5

endmodule

bind xcvr_core xcvr_core_chk #(.W(W)) chk_i (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_ce_n(ab_ce_n), .ab_le(ab_le), .ab_oe_n(ab_oe_n),
    .ba_le(ba_le), .ba_oe_n(ba_oe_n),
    .a_out(a_out), .a_out_en(a_out_en), .b_out_en(b_out_en)
);

// File: tb/xcvr_core_tb_top.sv
module xcvr_core_tb_top;

    localparam int W = 18;
    localparam logic [W-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic ab_ce_n = 1'b1, ab_le = 1'b0, ab_clk = 1'b0, ab_oe_n = 1'b1;
    logic ba_ce_n = 1'b1, ba_le = 1'b0, ba_clk = 1'b0, ba_oe_n = 1'b1;
    logic [W-1:0] a_out, a_out_en, b_out, b_out_en;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [W-1:0] a_val;
        logic [W-1:0] a_en;
        logic [W-1:0] b_en;
        string        tag;
    } exp_t;

    exp_t exp_q[$];

    // reference state, kept from the requirements
    logic [W-1:0] m_ab, m_ba;
    logic         m_ab_prev, m_ba_prev;

    always #10 clk = ~clk;

    xcvr_core #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ab_ce_n(ab_ce_n), .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe_n(ab_oe_n),
        .ba_ce_n(ba_ce_n), .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n),
        .a_out(a_out), .a_out_en(a_out_en), .b_out(b_out), .b_out_en(b_out_en)
    );

    task automatic model_reset();
        m_ab = '0; m_ba = '0; m_ab_prev = 1'b1; m_ba_prev = 1'b1;
    endtask

    // inputs are already set for this cycle; predict the post-edge outputs
    task automatic tick(input string tag);
        exp_t e;
        logic [W-1:0] d_ab, d_ba;
        if (ab_le || (!ab_ce_n && !m_ab_prev && ab_clk)) m_ab = a_in;
        if (ba_le || (!ba_ce_n && !m_ba_prev && ba_clk)) m_ba = b_in;
        m_ab_prev = ab_clk;
        m_ba_prev = ba_clk;
        d_ab = ab_le ? a_in : m_ab;
        d_ba = ba_le ? b_in : m_ba;
        e.b_en  = ab_oe_n ? '0 : ~d_ab;
        e.a_val = ba_oe_n ? '0 : d_ba;
        e.a_en  = ba_oe_n ? '0 : ONES;
        e.tag   = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic direct_check(input string tag, input logic [W-1:0] act,
                                input logic [W-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // monitor: compares mid-cycle after the edge that follows each drive
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                direct_check({e.tag, " b_out_en"}, b_out_en, e.b_en);
                direct_check({e.tag, " a_out"}, a_out, e.a_val);
                direct_check({e.tag, " a_out_en"}, a_out_en, e.a_en);
                direct_check("R8 b_out level", b_out, '0);
            end
        end
    end

    // contention monitor: both directions must never be enabled together
    always @(posedge clk) begin
        if (!rst && !ab_oe_n && !ba_oe_n) begin
            errors++;
            $display("FAIL contention both enables low actual=1 expected=0");
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset silences outputs even with a direction enabled and open
        ab_oe_n = 1'b0; ab_le = 1'b1; a_in = 18'h0_1234;
        @(posedge clk); #5;
        direct_check("R1 reset b_out_en", b_out_en, '0);
        direct_check("R1 reset a_out_en", a_out_en, '0);
        @(negedge clk);
        ab_le = 1'b0; a_in = '0;
        rst = 1'b0;
        model_reset();

        tick("R1 stored zero after reset");          // all bits pulled low
        // R2 transparent path
        ab_le = 1'b1; a_in = 18'h2_A5A5; tick("R2 transparent");
        a_in = 18'h1_5A5A; ab_ce_n = 1'b0; ab_clk = 1'b1; tick("R2 transparent ce/clk ignored");
        // R6 latch close
        ab_le = 1'b0; a_in = 18'h3_F00F; tick("R6 latch close holds");
        // R4 hold with strobe high then low
        a_in = 18'h0_0001; tick("R4 hold strobe high");
        ab_clk = 1'b0; tick("R4 hold strobe low");
        // R3 capture
        a_in = 18'h0_F0F0; ab_clk = 1'b1; tick("R3 capture");
        ab_clk = 1'b0; a_in = '0; tick("R4 hold after capture");
        // R5 inhibit
        ab_ce_n = 1'b1; ab_clk = 1'b1; a_in = 18'h3_3333; tick("R5 inhibit rise");
        ab_clk = 1'b0; tick("R5 inhibit low");
        ab_clk = 1'b1; tick("R5 inhibit second rise");
        // R11 enable sampled at the rising edge only
        ab_clk = 1'b0; ab_ce_n = 1'b0; tick("R11 enable low no rise");
        ab_ce_n = 1'b1; ab_clk = 1'b1; a_in = 18'h1_1111; tick("R11 enable high at rise");
        ab_ce_n = 1'b0; tick("R11 enable low after rise");
        ab_clk = 1'b0; tick("R11 strobe low");
        ab_clk = 1'b1; a_in = 18'h2_2222; tick("R3 capture again");
        // R7 A-to-B disabled
        ab_oe_n = 1'b1; tick("R7 ab disabled");
        // B-to-A direction
        ba_oe_n = 1'b0; ba_le = 1'b1; b_in = 18'h2_AAAA; tick("R9 ba transparent");
        ba_le = 1'b0; ba_ce_n = 1'b0; ba_clk = 1'b0; b_in = 18'h0_0F0F; tick("R9 ba latch hold");
        b_in = 18'h1_2345; ba_clk = 1'b1; tick("R9 ba capture");
        a_in = 18'h3_FFFF; ab_clk = 1'b0; tick("R10 ab activity");
        ab_clk = 1'b1; ab_ce_n = 1'b1; b_in = 18'h0_0000; tick("R10 ba holds");
        ba_oe_n = 1'b1; tick("R7 ba disabled");
        // R8 and R10: A-to-B value unchanged by B-to-A activity
        ab_oe_n = 1'b0; tick("R8 open drain pattern");
        ab_oe_n = 1'b1; tick("R7 ab off again");

        // R12: strobe high out of reset is not a rise
        rst = 1'b1; ab_clk = 1'b1; ab_ce_n = 1'b0; ab_le = 1'b0; a_in = 18'h0_5555;
        @(negedge clk); @(negedge clk);
        rst = 1'b0; model_reset();
        ab_oe_n = 1'b0; tick("R12 no rise after reset");
        ab_clk = 1'b0; tick("R12 strobe low");
        ab_clk = 1'b1; tick("R12 true rise captures");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule